// File: doc/BRIEF.md
# Receive Character Queue with Error Tags

This block is the receive-side character queue of a serial port. A deserializer hands it one character at a time, together with the parity-error and framing-error verdicts for that character. The block stores each character and its two verdicts as one tagged entry. The bus side pops the entries in arrival order. Each popped entry returns the character in its low byte and the two error tags above it.

The block reports how full it is through a combined index word. The receive occupancy sits in the upper field of that word and a transmit occupancy, supplied from outside, sits in the lower field. The bus side can flush the queue by writing a control value. While the flush runs, the flush bits read back as set, and they clear by themselves when it ends. A character that arrives while the queue is full is discarded, and an overrun event is raised for it. A pop from an empty queue can be answered with a bus error when software has enabled that option. An almost-full indication is also provided.

Top module: `rx_tagq`

## Requirements
- R1: A popped entry is presented on `pop_entry` in the same cycle as `pop_req`, as {frame error in bit 9, parity error in bit 8, character in bits 7:0}, exactly as it was pushed.
- R2: The queue holds 16 entries (DEPTH) and returns them in first-in, first-out order.
- R3: A push that arrives while the queue holds 16 entries and no pop happens in the same cycle is discarded. `overrun_evt` is high for exactly the one cycle after that push, and the stored contents do not change.
- R4: `index_word` carries the receive occupancy (0 to 16) in bits 12:8, `tx_level` in bits 4:0, and zeros in bits 7:5. It reflects the occupancy one cycle after a push or a pop.
- R5: A write to `ctl_wr` with `ctl_wdata[3:2]` equal to 2'b11 empties the queue at the next edge. `flush_bits` then reads 2'b11 for FLUSH_CYCLES (4) cycles and reads 2'b00 afterwards. Pushes and pops made during that time have no effect. A write with any other value in bits 3:2 does nothing.
- R6: A pop while the queue is empty returns zero on `pop_entry`. `bus_err` is high in that cycle only if `err_on_empty` is set.
- R7: When `seven_bit` is high at the time of a push, bit 7 of the stored character is zero. The other bits are kept.
- R8: A push and a pop in the same cycle on a full queue both take effect: the occupancy stays at 16 and no overrun is raised. On an empty queue, the pop returns nothing and the push is stored, so the occupancy becomes 1.
- R9: `almost_full` is high exactly when the occupancy is 12 (AF_LEVEL) or more.
- R10: A pop from an empty queue does not move the read position. The next pushed entry is the next one popped.
- R11: After reset the occupancy is 0 and `overrun_evt`, `almost_full`, `bus_err` and `flush_bits` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_vld | input | 1 | A received character is offered this cycle |
| push_char | input | 8 | Received character |
| push_perr | input | 1 | Parity error for the character |
| push_ferr | input | 1 | Framing error for the character |
| seven_bit | input | 1 | Seven-bit character mode |
| pop_req | input | 1 | Bus read of the queue this cycle |
| err_on_empty | input | 1 | Answer an empty pop with a bus error |
| ctl_wr | input | 1 | Write strobe of the control value |
| ctl_wdata | input | 4 | Control write data; bits 3:2 = 2'b11 start a flush |
| tx_level | input | 5 | Transmit occupancy passed into the index word |
| pop_entry | output | 10 | Popped entry {ferr, perr, char} |
| bus_err | output | 1 | Error response for an empty pop |
| overrun_evt | output | 1 | One-cycle overrun event |
| almost_full | output | 1 | Occupancy at or above AF_LEVEL |
| index_word | output | 13 | {rx occupancy, 3'b0, tx occupancy} |
| flush_bits | output | 2 | Flush-in-progress bits, read as 2'b11 while busy |

## Verification
The hardest states to reach are the edges of the occupancy: a push and a pop in the same cycle on a completely full queue, and the same on an empty one. Both require filling or draining the queue exactly and then raising both strobes together. The bench also has to show that discarded writes changed nothing. To do that, it drains the whole queue after an overrun and after pushes made during a flush, and it compares every entry against its own model. The flush window is timed edge by edge from the control write.

// File: rtl/rx_tagq_pkg.sv
package rx_tagq_pkg;
  typedef struct packed {
    logic       ferr;
    logic       perr;
    logic [7:0] ch;
  } rxq_entry_t;

  function automatic rxq_entry_t rxq_pack(input logic [7:0] ch, input logic perr,
                                          input logic ferr, input logic seven);
    rxq_entry_t e;
    e.ch   = seven ? {1'b0, ch[6:0]} : ch;
    e.perr = perr;
    e.ferr = ferr;
    return e;
  endfunction
endpackage

// File: rtl/rxq_flush.sv
module rxq_flush #(
  parameter int FLUSH_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int FW = $clog2(FLUSH_CYCLES + 1);
  logic [FW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (start)     cnt <= FW'(FLUSH_CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_FLUSH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R5
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int DEPTH    = 16,
  parameter int AF_LEVEL = 12,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          blocked,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          do_push,
  output logic          do_pop,
  output logic          drop,
  output logic          empty,
  output logic          full,
  output logic          af,
  output logic [CW-1:0] level
);
  function automatic logic [CW-1:0] lvl_next(input logic [CW-1:0] l,
                                             input logic p, input logic q);
    case ({p, q})
      2'b10:   return l + 1'b1;
      2'b01:   return l - 1'b1;
      default: return l;
    endcase
  endfunction

  assign empty   = (level == '0);
  assign full    = (level == CW'(DEPTH));
  assign af      = (level >= CW'(AF_LEVEL));
  assign do_pop  = pop_req & ~empty & ~blocked;
  assign do_push = push_req & ~blocked & (~full | do_pop);
  assign drop    = push_req & ~blocked & full & ~do_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   level <= '0;
    else if (clr) level <= '0;
    else          level <= lvl_next(level, do_push, do_pop);
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH)); // R2
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && pop_req && !blocked && !clr) |=> full); // R8
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rx_tagq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       wr_en,
  input  rxq_entry_t wr_entry,
  input  logic       rd_en,
  input  logic       rd_req,
  input  logic       empty,
  output rxq_entry_t rd_entry
);
  rxq_entry_t    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem[wptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_en) wptr <= ptr_inc(wptr);
      if (rd_en) rptr <= ptr_inc(rptr);
    end
  end

  assign rd_entry = mem[rptr];

  AST_EMPTY_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty && !clr) |=> $stable(rptr)); // R10
endmodule

// File: rtl/rx_tagq.sv
module rx_tagq
  import rx_tagq_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int AF_LEVEL     = 12,
  parameter int FLUSH_CYCLES = 4,
  localparam int CW          = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_vld,
  input  logic [7:0]      push_char,
  input  logic            push_perr,
  input  logic            push_ferr,
  input  logic            seven_bit,
  input  logic            pop_req,
  input  logic            err_on_empty,
  input  logic            ctl_wr,
  input  logic [3:0]      ctl_wdata,
  input  logic [CW-1:0]   tx_level,
  output logic [9:0]      pop_entry,
  output logic            bus_err,
  output logic            overrun_evt,
  output logic            almost_full,
  output logic [2*CW+2:0] index_word,
  output logic [1:0]      flush_bits
);
  logic          flush_start, flushing;
  logic          do_push, do_pop, drop, empty, full;
  logic [CW-1:0] level;
  rxq_entry_t    in_entry, head;

  assign flush_start = ctl_wr & (ctl_wdata[3:2] == 2'b11);
  assign in_entry    = rxq_pack(push_char, push_perr, push_ferr, seven_bit);

  rxq_flush #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_flush (
    .clk(clk), .rst_n(rst_n), .start(flush_start), .busy(flushing));

  rxq_level #(.DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL)) u_level (
    .clk(clk), .rst_n(rst_n), .clr(flush_start), .blocked(flushing),
    .push_req(push_vld), .pop_req(pop_req), .do_push(do_push), .do_pop(do_pop),
    .drop(drop), .empty(empty), .full(full), .af(almost_full), .level(level));

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(flush_start), .wr_en(do_push),
    .wr_entry(in_entry), .rd_en(do_pop), .rd_req(pop_req), .empty(empty),
    .rd_entry(head));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overrun_evt <= 1'b0;
    else        overrun_evt <= drop & ~flush_start;
  end

  assign pop_entry  = do_pop ? head : '0;
  assign bus_err    = pop_req & empty & err_on_empty;
  assign index_word = {level, 3'b000, tx_level};
  assign flush_bits = {2{flushing}};

  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |-> $past(full)); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_start |=> (level == '0)); // R5
  AST_ERR_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (empty && err_on_empty)); // R6
  AST_AF_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    almost_full |-> (index_word[2*CW+2:CW+3] >= CW'(AF_LEVEL))); // R9
endmodule

// File: tb/rx_tagq_test.sv
module rx_tagq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_vld = 0, push_perr = 0, push_ferr = 0, seven_bit = 0;
  logic [7:0] push_char = 0;
  logic pop_req = 0, err_on_empty = 0, ctl_wr = 0;
  logic [3:0] ctl_wdata = 0;
  logic [4:0] tx_level = 0;
  logic [9:0] pop_entry;
  logic bus_err, overrun_evt, almost_full;
  logic [12:0] index_word;
  logic [1:0] flush_bits;

  int errs = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_tagq uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push1(input logic [9:0] e);
    push_vld = 1; push_char = e[7:0]; push_perr = e[8]; push_ferr = e[9];
    tick();
    push_vld = 0;
  endtask

  task automatic pop1(input string req, input int exp);
    pop_req = 1; #1;
    chk(req, pop_entry, exp);
    tick();
    pop_req = 0;
  endtask

  function automatic logic [9:0] pat(input int i);
    return 10'((i * 37 + 11) ^ (i << 7));
  endfunction

  task automatic t_reset();
    chk("R11 level", index_word[12:8], 0);
    chk("R11 flags", {overrun_evt, almost_full, bus_err, flush_bits}, 0);
  endtask

  task automatic t_format();
    push1(10'h2A5); push1(10'h15A); push1(10'h0FF);
    chk("R4 index", index_word, {5'd3, 3'b0, 5'd0});
    tx_level = 5'd9; #1;
    chk("R4 tx field", index_word, {5'd3, 3'b0, 5'd9});
    tx_level = 0;
    pop1("R1 entry0", 10'h2A5); pop1("R1 entry1", 10'h15A); pop1("R1 entry2", 10'h0FF);
    chk("R4 drained", index_word[12:8], 0);
  endtask

  task automatic t_empty_read();
    err_on_empty = 0; pop_req = 1; #1;
    chk("R6 no err", bus_err, 0); chk("R6 zero data", pop_entry, 0);
    tick();
    err_on_empty = 1; #1;
    chk("R6 err", bus_err, 1);
    tick(); pop_req = 0; err_on_empty = 0;
    push1(10'h133);
    pop1("R10 read pos kept", 10'h133);
  endtask

  task automatic t_fill_overrun();
    for (int i = 0; i < 16; i++) begin
      push1(pat(i));
      if (i == 10) chk("R9 af at 11", almost_full, 0);
      if (i == 11) chk("R9 af at 12", almost_full, 1);
    end
    chk("R2 full level", index_word[12:8], 16);
    push1(10'h3C3);
    chk("R3 overrun", overrun_evt, 1);
    tick();
    chk("R3 one cycle", overrun_evt, 0);
    chk("R3 level kept", index_word[12:8], 16);
    push_vld = 1; push_char = 8'h77; push_perr = 0; push_ferr = 1; pop_req = 1; #1;
    chk("R8 full swap data", pop_entry, pat(0));
    tick(); push_vld = 0; pop_req = 0;
    chk("R8 full level", index_word[12:8], 16);
    chk("R8 no overrun", overrun_evt, 0);
    for (int i = 1; i < 16; i++) pop1("R2 order", pat(i));
    pop1("R8 swapped entry", 10'h277);
    chk("R9 af low", almost_full, 0);
  endtask

  task automatic t_empty_swap();
    push_vld = 1; push_char = 8'h5E; push_perr = 1; push_ferr = 0; pop_req = 1; #1;
    chk("R8 empty pop data", pop_entry, 0);
    tick(); push_vld = 0; pop_req = 0;
    chk("R8 empty level", index_word[12:8], 1);
    pop1("R8 empty stored", 10'h15E);
  endtask

  task automatic t_seven();
    seven_bit = 1; push1(10'h3FF); seven_bit = 0;
    pop1("R7 bit7 clear", 10'h37F);
  endtask

  task automatic t_flush();
    push1(10'h011); push1(10'h022);
    ctl_wr = 1; ctl_wdata = 4'b0100; tick(); ctl_wr = 0;
    chk("R5 other value", index_word[12:8], 2);
    chk("R5 other busy", flush_bits, 0);
    ctl_wr = 1; ctl_wdata = 4'b1100; tick(); ctl_wr = 0;
    chk("R5 cleared", index_word[12:8], 0);
    chk("R5 busy", flush_bits, 3);
    push1(10'h099);
    tick(); tick();
    chk("R5 busy last", flush_bits, 3);
    tick();
    chk("R5 done", flush_bits, 0);
    chk("R5 push ignored", index_word[12:8], 0);
    push1(10'h0AB);
    pop1("R5 after flush", 10'h0AB);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset();
    t_format();
    t_empty_read();
    t_fill_overrun();
    t_empty_swap();
    t_seven();
    t_flush();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule